// File: doc/BRIEF.md
# Cross-Domain Isolation Enable Sequencer

This block controls the enable word of the isolation and level-shifting cells that sit between an always-on processor domain and a logic domain whose power can be switched. Software asks for power-up and power-down. The rail controller reports power-good. The configuration engine reports configuration-done. A hardware interlock says whether enabling the cells is safe at all. The sequencer turns the cells on in two steps. The processor-to-logic paths come on first. The logic-to-processor paths follow only after the logic domain has been configured. Power-down runs the steps in the opposite order, and the rail is not asked to drop until every cell is off.

A bypass write port lets software load the enable word directly while the domain is up and active. An optional watchdog on the configuration wait flags a configuration that never completes. Two conditions clear the word in the same cycle they occur, whatever the sequencer state: loss of power-good, and a low safe-to-enable interlock.

Top module: `iso_enable_seq`

## Requirements
- R1: A synchronous active-high reset leaves the enable word at 0x0, with ready, power-removal request and configuration error all low, and the sequencer in its off state.
- R2: The word stays 0x0 while the sequencer is off, and also after a power-up request while it waits for power-good. A power-up request is taken from the off state only.
- R3: On the first clock edge at which power-good is seen high after a power-up request, the word becomes 0x0A. Bits 1 and 3 are the processor-to-logic enables. Ready stays low.
- R4: With the word at 0x0A, a high configuration-done at a clock edge moves the word to 0x0F, where bits 0 and 2 are the logic-to-processor enables. Ready is high only in this fully enabled state.
- R5: A power-down request in the 0x0A or 0x0F state steps through three edges. The first edge drops ready and takes the word to 0x0A. The second takes the word to 0x0. The third raises the power-removal request. The request and the 0x0 word hold until power-good falls, which returns the sequencer to off.
- R6: In the 0x0A or 0x0F state with power-good high, a bypass write loads its data as the enable word from the next cycle. The loaded value holds until a power-down request or a loss of power-good. Ready is unchanged by the write.
- R7: A bypass write is ignored while power-good is low, and also in any state other than the 0x0A and 0x0F states.
- R8: Every enable bit and ready read 0 while safe-to-enable is low, in any state. The sequencer state is kept, so the word returns when safe-to-enable rises again.
- R9: If power-good falls in any state past the power-good wait, the word and ready drop to 0 in the same cycle and the sequencer returns to off at the next edge.
- R10: If configuration-done stays low for TIMEOUT_CYC edges in the 0x0A state, the configuration error flag rises. From then on the word holds 0x0A and configuration-done is ignored until power-down or power loss clears the flag. TIMEOUT_CYC of 0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Logic domain power is good |
| cfg_done_i | input | 1 | Logic domain configuration has completed |
| hw_safe_i | input | 1 | Hardware interlock: enabling is safe |
| up_req_i | input | 1 | Software power-up request |
| down_req_i | input | 1 | Software power-down request |
| byp_wr_i | input | 1 | Bypass write strobe |
| byp_data_i | input | EN_W | Bypass enable word |
| en_o | output | EN_W | Isolation cell enable word |
| ready_o | output | 1 | Cross-domain interfaces may be used |
| pwr_off_req_o | output | 1 | Request to remove logic domain power |
| cfg_err_o | output | 1 | Configuration wait timed out |

## Verification
The bench builds the block with TIMEOUT_CYC set to 4 instead of the default 1024. At that value the configuration timeout, the latched error and the point at which configuration-done is ignored can all be reached within a few vectors. The enable width and the two stage masks keep their defaults of 4, 0x0A and 0x0F, so the expected words match the requirements directly. Directed tests check the same-cycle clear on power loss before the clock edge that follows it. They also cover power-down from the half-enabled state, a reset in the middle of a run, and a bypass write made in the power-good wait.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_WAIT_PG = 3'd1,
        ST_OUTBND  = 3'd2,
        ST_FULL    = 3'd3,
        ST_DRAIN   = 3'd4,
        ST_ISOLATE = 3'd5,
        ST_PWROFF  = 3'd6
    } seq_state_e;

    localparam logic [3:0] DEF_OUT_MASK = 4'hA;
    localparam logic [3:0] DEF_ALL_MASK = 4'hF;

    // States in which the domain is up and software may override the word
    function automatic logic is_active(input seq_state_e st);
        return (st == ST_OUTBND) || (st == ST_FULL);
    endfunction

    // States in which power-good is expected to be high
    function automatic logic expects_power(input seq_state_e st);
        return (st != ST_OFF) && (st != ST_WAIT_PG);
    endfunction

    // States that drive the outbound-only word
    function automatic logic is_outbound_stage(input seq_state_e st);
        return (st == ST_OUTBND) || (st == ST_DRAIN);
    endfunction

endpackage

// File: rtl/iso_seq_fsm.sv
module iso_seq_fsm
    import iso_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good_i,
    input  logic       cfg_done_i,
    input  logic       up_req_i,
    input  logic       down_req_i,
    input  logic       cfg_err_i,
    output seq_state_e state_o,
    output seq_state_e next_o
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!pwr_good_i && expects_power(state_q)) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     if (up_req_i) state_d = ST_WAIT_PG;
                ST_WAIT_PG: if (pwr_good_i) state_d = ST_OUTBND;
                ST_OUTBND: begin
                    if (down_req_i)
                        state_d = ST_DRAIN;
                    else if (cfg_done_i && !cfg_err_i)
                        state_d = ST_FULL;
                end
                ST_FULL:    if (down_req_i) state_d = ST_DRAIN;
                ST_DRAIN:   state_d = ST_ISOLATE;
                ST_ISOLATE: state_d = ST_PWROFF;
                ST_PWROFF:  state_d = ST_PWROFF;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
    assign next_o  = state_d;

    // R9: power loss past the wait returns to off
    a_r9_pgloss_off: assert property (@(posedge clk) disable iff (rst)
        (!pwr_good_i && expects_power(state_q)) |=> (state_q == ST_OFF));

    // R5: power-removal request is entered only from the isolate step
    a_r5_pwroff_after_isolate: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PWROFF && $past(state_q) != ST_PWROFF) |-> ($past(state_q) == ST_ISOLATE));

endmodule

// File: rtl/iso_cfg_timer.sv
module iso_cfg_timer
    import iso_seq_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_i,
    input  seq_state_e next_i,
    input  logic       cfg_done_i,
    output logic       cfg_err_o
);

    generate
        if (TIMEOUT_CYC == 0) begin : g_no_timer
            assign cfg_err_o = 1'b0;
        end else begin : g_timer
            localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

            logic [CNT_W-1:0] cnt_q;
            logic             err_q;

            always_ff @(posedge clk) begin
                if (rst || next_i != ST_OUTBND) begin
                    cnt_q <= '0;
                    err_q <= 1'b0;
                end else if (state_i == ST_OUTBND && !cfg_done_i && !err_q) begin
                    if (cnt_q == LAST) err_q <= 1'b1;
                    else               cnt_q <= cnt_q + 1'b1;
                end
            end

            assign cfg_err_o = err_q;

            // R10: the error flag only exists in the outbound-only state
            a_r10_err_in_stage: assert property (@(posedge clk) disable iff (rst)
                err_q |-> (state_i == ST_OUTBND));

            // R10: once raised, the flag stays while the stage persists
            a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
                (err_q && state_i == ST_OUTBND && next_i == ST_OUTBND) |=> err_q);
        end
    endgenerate

endmodule

// File: rtl/iso_bypass_reg.sv
module iso_bypass_reg
    import iso_seq_pkg::*;
#(
    parameter int EN_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_state_e      state_i,
    input  seq_state_e      next_i,
    input  logic            pwr_good_i,
    input  logic            wr_i,
    input  logic [EN_W-1:0] data_i,
    output logic            active_o,
    output logic [EN_W-1:0] value_o
);

    logic            act_q;
    logic [EN_W-1:0] val_q;
    logic            accept;

    assign accept = wr_i && pwr_good_i && is_active(state_i);

    always_ff @(posedge clk) begin
        if (rst || !is_active(next_i)) begin
            act_q <= 1'b0;
            val_q <= '0;
        end else if (accept) begin
            act_q <= 1'b1;
            val_q <= data_i;
        end
    end

    assign active_o = act_q;
    assign value_o  = val_q;

    // R7: the override never survives outside the active stages
    a_r7_override_active_only: assert property (@(posedge clk) disable iff (rst)
        act_q |-> is_active(state_i));

endmodule

// File: rtl/iso_en_gate.sv
module iso_en_gate
    import iso_seq_pkg::*;
#(
    parameter int              EN_W     = 4,
    parameter logic [EN_W-1:0] OUT_MASK = EN_W'(DEF_OUT_MASK),
    parameter logic [EN_W-1:0] ALL_MASK = EN_W'(DEF_ALL_MASK)
) (
    input  seq_state_e      state_i,
    input  logic            pwr_good_i,
    input  logic            hw_safe_i,
    input  logic            byp_active_i,
    input  logic [EN_W-1:0] byp_value_i,
    output logic [EN_W-1:0] en_o,
    output logic            ready_o,
    output logic            pwr_off_req_o
);

    logic [EN_W-1:0] stage_word;
    logic [EN_W-1:0] raw_word;
    logic            allow;

    always_comb begin
        if (state_i == ST_FULL)               stage_word = ALL_MASK;
        else if (is_outbound_stage(state_i))  stage_word = OUT_MASK;
        else                                  stage_word = '0;
    end

    assign raw_word = byp_active_i ? byp_value_i : stage_word;
    assign allow    = pwr_good_i && hw_safe_i;

    generate
        for (genvar b = 0; b < EN_W; b++) begin : g_bit
            assign en_o[b] = raw_word[b] & allow;
        end
    endgenerate

    assign ready_o       = (state_i == ST_FULL) && allow;
    assign pwr_off_req_o = (state_i == ST_PWROFF);

endmodule

// File: rtl/iso_enable_seq.sv
module iso_enable_seq
    import iso_seq_pkg::*;
#(
    parameter int              EN_W        = 4,
    parameter logic [EN_W-1:0] OUT_MASK    = EN_W'(DEF_OUT_MASK),
    parameter logic [EN_W-1:0] ALL_MASK    = EN_W'(DEF_ALL_MASK),
    parameter int              TIMEOUT_CYC = 1024
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_good_i,
    input  logic            cfg_done_i,
    input  logic            hw_safe_i,
    input  logic            up_req_i,
    input  logic            down_req_i,
    input  logic            byp_wr_i,
    input  logic [EN_W-1:0] byp_data_i,
    output logic [EN_W-1:0] en_o,
    output logic            ready_o,
    output logic            pwr_off_req_o,
    output logic            cfg_err_o
);

    seq_state_e      state, next_state;
    logic            byp_active;
    logic [EN_W-1:0] byp_value;

    iso_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwr_good_i (pwr_good_i),
        .cfg_done_i (cfg_done_i),
        .up_req_i   (up_req_i),
        .down_req_i (down_req_i),
        .cfg_err_i  (cfg_err_o),
        .state_o    (state),
        .next_o     (next_state)
    );

    iso_cfg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .state_i    (state),
        .next_i     (next_state),
        .cfg_done_i (cfg_done_i),
        .cfg_err_o  (cfg_err_o)
    );

    iso_bypass_reg #(.EN_W(EN_W)) u_bypass (
        .clk        (clk),
        .rst        (rst),
        .state_i    (state),
        .next_i     (next_state),
        .pwr_good_i (pwr_good_i),
        .wr_i       (byp_wr_i),
        .data_i     (byp_data_i),
        .active_o   (byp_active),
        .value_o    (byp_value)
    );

    iso_en_gate #(.EN_W(EN_W), .OUT_MASK(OUT_MASK), .ALL_MASK(ALL_MASK)) u_gate (
        .state_i       (state),
        .pwr_good_i    (pwr_good_i),
        .hw_safe_i     (hw_safe_i),
        .byp_active_i  (byp_active),
        .byp_value_i   (byp_value),
        .en_o          (en_o),
        .ready_o       (ready_o),
        .pwr_off_req_o (pwr_off_req_o)
    );

    // R2: nothing is enabled before the domain is up
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF || state == ST_WAIT_PG) |-> (en_o == '0 && !ready_o));

    // R4: ready implies the full word unless software overrode it
    a_r4_ready_full: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (byp_active || en_o == ALL_MASK));

    // R5: power removal is requested only with every cell off
    a_r5_offreq_isolated: assert property (@(posedge clk) disable iff (rst)
        pwr_off_req_o |-> (en_o == '0 && !ready_o));

    // R5: ready falls before the word reaches zero on power-down
    a_r5_ready_first: assert property (@(posedge clk) disable iff (rst)
        (ready_o && down_req_i && pwr_good_i) |=> (!ready_o && (!hw_safe_i || !pwr_good_i || en_o == OUT_MASK)));

    // R8: a low interlock keeps every output enable off
    a_r8_interlock: assert property (@(posedge clk) disable iff (rst)
        !hw_safe_i |-> (en_o == '0 && !ready_o));

endmodule

// File: tb/tb_iso_enable_seq.sv
module tb_iso_enable_seq;

    localparam int EN_W = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            pwr_good_i = 1'b0;
    logic            cfg_done_i = 1'b0;
    logic            hw_safe_i = 1'b1;
    logic            up_req_i = 1'b0;
    logic            down_req_i = 1'b0;
    logic            byp_wr_i = 1'b0;
    logic [EN_W-1:0] byp_data_i = '0;
    logic [EN_W-1:0] en_o;
    logic            ready_o;
    logic            pwr_off_req_o;
    logic            cfg_err_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    iso_enable_seq #(.EN_W(EN_W), .TIMEOUT_CYC(4)) dut (
        .clk           (clk),
        .rst           (rst),
        .pwr_good_i    (pwr_good_i),
        .cfg_done_i    (cfg_done_i),
        .hw_safe_i     (hw_safe_i),
        .up_req_i      (up_req_i),
        .down_req_i    (down_req_i),
        .byp_wr_i      (byp_wr_i),
        .byp_data_i    (byp_data_i),
        .en_o          (en_o),
        .ready_o       (ready_o),
        .pwr_off_req_o (pwr_off_req_o),
        .cfg_err_o     (cfg_err_o)
    );

    typedef struct packed {
        logic       pg, cfg, safe, up, dn, wr;
        logic [3:0] data;
        logic [3:0] en;
        logic       rdy, off, err;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b0,1'b0, 4'd2},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b0,1'b0, 4'd2},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b0, 4'd3},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b0, 4'd3},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hF,1'b1,1'b0,1'b0, 4'd4},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b0,1'b0, 4'd8},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hF,1'b1,1'b0,1'b0, 4'd8},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,4'h3, 4'h3,1'b1,1'b0,1'b0, 4'd6},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b0,1'b0, 4'd8},
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b0, 4'd5},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b0,1'b0, 4'd5},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b1,1'b0, 4'd5},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,4'hF, 4'h0,1'b0,1'b1,1'b0, 4'd7},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b0,1'b0, 4'd5},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,4'hF, 4'h0,1'b0,1'b0,1'b0, 4'd7},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b0,1'b0, 4'd2},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b0, 4'd3},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b0, 4'd10},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b0, 4'd10},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b0, 4'd10},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b1, 4'd10},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b1, 4'd10},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b0,1'b0, 4'd9}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] e_en, input logic e_rdy,
                         input logic e_off, input logic e_err);
        n_checks++;
        if (en_o !== e_en || ready_o !== e_rdy || pwr_off_req_o !== e_off || cfg_err_o !== e_err) begin
            n_errors++;
            $display("FAIL %s: got en=%h rdy=%b off=%b err=%b, expected en=%h rdy=%b off=%b err=%b",
                     tag, en_o, ready_o, pwr_off_req_o, cfg_err_o, e_en, e_rdy, e_off, e_err);
        end
    endtask

    task automatic drive(input logic pg, input logic cfg, input logic safe, input logic up,
                         input logic dn, input logic wr, input logic [3:0] data);
        @(negedge clk);
        pwr_good_i = pg; cfg_done_i = cfg; hw_safe_i = safe;
        up_req_i = up; down_req_i = dn; byp_wr_i = wr; byp_data_i = data;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic pg);
        drive(pg, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset", 4'h0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // main vector walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].pg, VEC[i].cfg, VEC[i].safe, VEC[i].up, VEC[i].dn, VEC[i].wr, VEC[i].data);
            check($sformatf("%s vec%0d", req_name(VEC[i].req), i), VEC[i].en, VEC[i].rdy, VEC[i].off, VEC[i].err);
        end

        // R9: same-cycle clear on power loss, before the next edge
        do_reset();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
        check("R4 full before loss", 4'hF, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        pwr_good_i = 1'b0;
        #1;
        check("R9 same-cycle clear", 4'h0, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        #1;
        idle(1'b1);
        check("R9 returned to off", 4'h0, 1'b0, 1'b0, 1'b0);

        // R5: power-down from the outbound-only stage
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
        check("R3 outbound after up", 4'hA, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0);
        check("R5 drain from outbound", 4'hA, 1'b0, 1'b0, 1'b0);
        idle(1'b1);
        check("R5 isolate", 4'h0, 1'b0, 1'b0, 1'b0);
        idle(1'b1);
        check("R5 power-off request", 4'h0, 1'b0, 1'b1, 1'b0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0);
        check("R5 request holds", 4'h0, 1'b0, 1'b1, 1'b0);

        // R1: reset in the middle of a fully enabled run
        do_reset();
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
        check("R4 full again", 4'hF, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", 4'h0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R7: write during the power-good wait is ignored
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h5);
        check("R7 write in wait", 4'hA, 1'b0, 1'b0, 1'b0);
        idle(1'b1);
        check("R7 write in wait stays ignored", 4'hA, 1'b0, 1'b0, 1'b0);

        // R6: bypass in the outbound stage, cleared by power loss
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h6);
        check("R6 bypass in outbound", 4'h6, 1'b0, 1'b0, 1'b0);
        idle(1'b0);
        check("R9 bypass lost with power", 4'h0, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule